// File: doc/BRIEF.md
# Soft-Sectored Track Format Sequencer

This block produces, one byte at a time, the complete byte stream written to a soft-sectored disk track during a format pass. The host arms the block with a start pulse and gives it the cylinder, the head and the number of sectors. Writing begins at the next rising edge of the index signal. The block then lays down a lead-in gap. For each sector, numbered from 1, it writes:

- a zero sync run, a two-byte ID address mark, four ID bytes and a two-byte CRC slot;
- an inter-field gap;
- another sync run, a two-byte data address mark, 256 fill bytes and a two-byte CRC slot;
- a trailing gap.

After the last sector it pads with gap filler until the index edge returns. That second index edge ends the pass.

A downstream serializer pulls bytes with a one-cycle ready strobe. The byte on `wrByte` is the one being offered, and the strobe consumes it. A separate flag marks the first address-mark byte, which the encoder must write with a missing clock bit. CRC arithmetic lives in a separate unit. This block only drives the strobes for that unit: clear, accumulate, and send-CRC-in-this-slot. When the pass ends, the block reports how many data fields were completed. If the track ran out before the last data CRC slot was written, it also raises an overrun flag.

Top module: `trkfmt_top`

## Requirements
- R1: After `startFmt` the block waits with `writeGate` low, accepting and ignoring `byteReady`. The first rising edge of `indexPulse` raises `writeGate` on the next clock, with the first lead-in byte on `wrByte`.
- R2: The lead-in gap is `GAP1_LEN` bytes of 0x4E (default 16). A `GAP1_LEN` below 12 is rejected at elaboration.
- R3: Every address mark is preceded by `SYNC_LEN` bytes of 0x00 (default 12).
- R4: An address mark is two bytes: 0xA1 with `markByte` high, then 0xFE for an ID field or 0xF8 for a data field. `markByte` is high on no other byte.
- R5: The ID field that follows the 0xFE byte is, in order: cylinder bits 15:8, cylinder bits 7:0, head, and sector number. Sector numbers run from 1 to `sectorCount`. Cylinder and head are captured at `startFmt`.
- R6: Each ID field and each data field is followed by two CRC slots, with `crcSend` high and `wrByte` 0x00. `crcClr` is high on each 0xA1 byte. `crcAccum` is high on the mark, ID and data bytes and on no other byte.
- R7: A data field carries `DATA_LEN` (256) bytes of `FILL_BYTE` (default 0xE5).
- R8: Between the ID CRC and the data sync, a gap of `GAP2_LEN` 0x4E bytes is written (default 15). After each data CRC, a gap of `GAP3_LEN` 0x4E bytes is written (default 20). After the last sector's trailing gap, 0x4E is written for as long as bytes are taken.
- R9: The next rising index edge after writing began does the following on the next clock: it drops `writeGate`, pulses `fmtDone` for exactly one cycle, and presents on `secWritten` the number of data fields whose CRC slots completed.
- R10: `overrun` is set at the end of the pass if the ending index edge came before the last sector's data CRC slots were written. Otherwise it is cleared. It holds until the next `startFmt`.
- R11: The stream advances one byte per `byteReady` strobe and only then. Without a strobe, `wrByte`, `markByte` and the CRC strobes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startFmt | input | 1 | Arms a format pass; captures cylinder, head and sector count |
| indexPulse | input | 1 | Index signal, active high; its rising edge is used |
| cylinder | input | 16 | Cylinder number written in each ID field |
| head | input | 8 | Head number written in each ID field |
| sectorCount | input | 8 | Sectors per track, 1 or more |
| byteReady | input | 1 | Serializer has taken the offered byte |
| wrByte | output | 8 | Byte offered for writing |
| markByte | output | 1 | Offered byte is the missing-clock address-mark byte |
| crcClr | output | 1 | CRC unit clears before this byte |
| crcAccum | output | 1 | CRC unit folds in this byte |
| crcSend | output | 1 | This slot carries a CRC byte from the CRC unit |
| writeGate | output | 1 | Write enable toward the drive |
| fmtDone | output | 1 | One-cycle pulse at the end of a pass |
| secWritten | output | 8 | Data fields completed in the current or last pass |
| overrun | output | 1 | Last pass ended before its final data CRC |

## Verification
The assertions assume the following about the inputs:
- `startFmt` is pulsed only while the block is idle.
- `sectorCount` is at least 1.
- `byteReady` is a single-cycle strobe.
- Index edges are at least one clock apart.

The stimulus meets these assumptions. It raises the index for several cycles but counts only its first edge, and it issues start pulses only after a completed pass. Its ready strobes last exactly one cycle, with zero or more idle cycles between them. It sweeps sector counts, cylinder and head values, and the points at which the ending index edge lands.

// File: rtl/trkfmt_pkg.sv
package trkfmt_pkg;

  localparam int CYL_W  = 16;
  localparam int HEAD_W = 8;
  localparam int SEC_W  = 8;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] GAP_FILL  = 8'h4E;
  localparam logic [BYTE_W-1:0] SYNC_FILL = 8'h00;
  localparam logic [BYTE_W-1:0] MARK_LEAD = 8'hA1;
  localparam logic [BYTE_W-1:0] MARK_ID   = 8'hFE;
  localparam logic [BYTE_W-1:0] MARK_DATA = 8'hF8;

  typedef enum logic [3:0] {
    F_IDLE,
    F_ARM,
    F_GAP1,
    F_SYNC_ID,
    F_AM_ID,
    F_ID,
    F_CRC_ID,
    F_GAP2,
    F_SYNC_DAT,
    F_AM_DAT,
    F_DATA,
    F_CRC_DAT,
    F_GAP3,
    F_GAP4
  } fmtField_e;

  typedef struct packed {
    fmtField_e        field;
    logic [1:0]       slot;
    logic [SEC_W-1:0] secNum;
    logic             capture;
  } fmtStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/trkfmt_ctrl.sv
module trkfmt_ctrl
  import trkfmt_pkg::*;
#(
  parameter int GAP1_LEN = 16,
  parameter int SYNC_LEN = 12,
  parameter int GAP2_LEN = 15,
  parameter int GAP3_LEN = 20,
  parameter int DATA_LEN = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startFmt,
  input  logic             indexPulse,
  input  logic [SEC_W-1:0] sectorCount,
  input  logic             byteReady,
  output fmtStrobe_t       strobe,
  output logic             writeGate,
  output logic             fmtDone,
  output logic [SEC_W-1:0] secWritten,
  output logic             overrun
);

  localparam int MAX_LEN = maxOf(maxOf(maxOf(GAP1_LEN, SYNC_LEN), maxOf(GAP2_LEN, GAP3_LEN)),
                                 maxOf(DATA_LEN, 4));
  localparam int CNT_W   = $clog2(MAX_LEN) + 1;

  if (GAP1_LEN < 12) begin : gGap1TooShort
    $error("trkfmt_ctrl: GAP1_LEN must be at least 12");
  end

  fmtField_e        curField;
  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] secNum;
  logic [SEC_W-1:0] secTotal;
  logic [SEC_W-1:0] doneSecs;
  logic             idxPrev;
  logic             idxRise;
  logic             active;
  logic             fieldEnd;

  function automatic logic [CNT_W-1:0] lastIdx(input fmtField_e f);
    case (f)
      F_GAP1:                 return CNT_W'(GAP1_LEN - 1);
      F_SYNC_ID, F_SYNC_DAT:  return CNT_W'(SYNC_LEN - 1);
      F_AM_ID, F_AM_DAT:      return CNT_W'(1);
      F_ID:                   return CNT_W'(3);
      F_CRC_ID, F_CRC_DAT:    return CNT_W'(1);
      F_GAP2:                 return CNT_W'(GAP2_LEN - 1);
      F_DATA:                 return CNT_W'(DATA_LEN - 1);
      F_GAP3:                 return CNT_W'(GAP3_LEN - 1);
      default:                return '1;
    endcase
  endfunction

  function automatic fmtField_e nextField(input fmtField_e f);
    case (f)
      F_GAP1:     return F_SYNC_ID;
      F_SYNC_ID:  return F_AM_ID;
      F_AM_ID:    return F_ID;
      F_ID:       return F_CRC_ID;
      F_CRC_ID:   return F_GAP2;
      F_GAP2:     return F_SYNC_DAT;
      F_SYNC_DAT: return F_AM_DAT;
      F_AM_DAT:   return F_DATA;
      F_DATA:     return F_CRC_DAT;
      F_CRC_DAT:  return F_GAP3;
      default:    return F_GAP4;
    endcase
  endfunction

  assign idxRise  = indexPulse && !idxPrev;
  assign active   = (curField != F_IDLE) && (curField != F_ARM);
  assign fieldEnd = (curField != F_GAP4) && (cnt == lastIdx(curField));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curField <= F_IDLE;
      cnt      <= '0;
      secNum   <= SEC_W'(1);
      secTotal <= '0;
      doneSecs <= '0;
      idxPrev  <= 1'b0;
      fmtDone  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      idxPrev <= indexPulse;
      fmtDone <= 1'b0;
      case (curField)
        F_IDLE: begin
          if (startFmt) begin
            curField <= F_ARM;
            secTotal <= sectorCount;
            overrun  <= 1'b0;
          end
        end
        F_ARM: begin
          if (idxRise) begin
            curField <= F_GAP1;
            cnt      <= '0;
            secNum   <= SEC_W'(1);
            doneSecs <= '0;
          end
        end
        default: begin
          if (idxRise) begin
            curField <= F_IDLE;
            cnt      <= '0;
            fmtDone  <= 1'b1;
            overrun  <= (doneSecs != secTotal);
          end else if (byteReady && curField != F_GAP4) begin
            if (fieldEnd) begin
              cnt <= '0;
              if (curField == F_CRC_DAT) begin
                doneSecs <= doneSecs + SEC_W'(1);
              end
              if (curField == F_GAP3) begin
                if (secNum == secTotal) begin
                  curField <= F_GAP4;
                end else begin
                  secNum   <= secNum + SEC_W'(1);
                  curField <= F_SYNC_ID;
                end
              end else begin
                curField <= nextField(curField);
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign writeGate      = active;
  assign secWritten     = doneSecs;
  assign strobe.field   = curField;
  assign strobe.slot    = cnt[1:0];
  assign strobe.secNum  = secNum;
  assign strobe.capture = (curField == F_IDLE) && startFmt;

  // R1: the gate only rises right after an index edge
  a_r1_gate_after_index: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeGate) |-> $past(indexPulse));

  // R9: an index edge during writing ends the pass
  a_r9_index_ends_pass: assert property (@(posedge clk) disable iff (!rstN)
    (active && idxRise) |=> (!writeGate && fmtDone));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    fmtDone |=> !fmtDone);

  // R11: no strobe, no movement
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (active && !byteReady && !idxRise) |=> ($stable(cnt) && $stable(curField)));

  // R5: sector numbers stay within the requested range
  a_r5_sector_range: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (secNum >= SEC_W'(1) && secNum <= secTotal));

  // R10: completed data fields never exceed the requested count
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (doneSecs <= secTotal));

endmodule

// File: rtl/trkfmt_dpath.sv
module trkfmt_dpath
  import trkfmt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hE5
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strobe,
  input  logic [CYL_W-1:0]  cylinder,
  input  logic [HEAD_W-1:0] head,
  output logic [BYTE_W-1:0] wrByte,
  output logic              markByte,
  output logic              crcClr,
  output logic              crcAccum,
  output logic              crcSend
);

  logic [CYL_W-1:0]  cylLatch;
  logic [HEAD_W-1:0] headLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cylLatch  <= '0;
      headLatch <= '0;
    end else if (strobe.capture) begin
      cylLatch  <= cylinder;
      headLatch <= head;
    end
  end

  always_comb begin
    wrByte   = SYNC_FILL;
    markByte = 1'b0;
    crcClr   = 1'b0;
    crcAccum = 1'b0;
    crcSend  = 1'b0;
    case (strobe.field)
      F_GAP1, F_GAP2, F_GAP3, F_GAP4: wrByte = GAP_FILL;
      F_SYNC_ID, F_SYNC_DAT:          wrByte = SYNC_FILL;
      F_AM_ID, F_AM_DAT: begin
        crcAccum = 1'b1;
        if (strobe.slot[0] == 1'b0) begin
          wrByte   = MARK_LEAD;
          markByte = 1'b1;
          crcClr   = 1'b1;
        end else begin
          wrByte = (strobe.field == F_AM_ID) ? MARK_ID : MARK_DATA;
        end
      end
      F_ID: begin
        crcAccum = 1'b1;
        case (strobe.slot)
          2'd0:    wrByte = cylLatch[15:8];
          2'd1:    wrByte = cylLatch[7:0];
          2'd2:    wrByte = headLatch;
          default: wrByte = strobe.secNum;
        endcase
      end
      F_DATA: begin
        crcAccum = 1'b1;
        wrByte   = FILL_BYTE;
      end
      F_CRC_ID, F_CRC_DAT: crcSend = 1'b1;
      default: wrByte = SYNC_FILL;
    endcase
  end

  // R4: the missing-clock flag only ever sits on the lead mark byte
  a_r4_mark_is_a1: assert property (@(posedge clk) disable iff (!rstN)
    markByte |-> (wrByte == MARK_LEAD && crcClr));

  // R6: a CRC slot is never folded into the CRC nor flagged as a mark
  a_r6_crc_slot_clean: assert property (@(posedge clk) disable iff (!rstN)
    crcSend |-> (!crcAccum && !markByte && !crcClr));

endmodule

// File: rtl/trkfmt_top.sv
module trkfmt_top
  import trkfmt_pkg::*;
#(
  parameter int                GAP1_LEN  = 16,
  parameter int                SYNC_LEN  = 12,
  parameter int                GAP2_LEN  = 15,
  parameter int                GAP3_LEN  = 20,
  parameter int                DATA_LEN  = 256,
  parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hE5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startFmt,
  input  logic              indexPulse,
  input  logic [CYL_W-1:0]  cylinder,
  input  logic [HEAD_W-1:0] head,
  input  logic [SEC_W-1:0]  sectorCount,
  input  logic              byteReady,
  output logic [BYTE_W-1:0] wrByte,
  output logic              markByte,
  output logic              crcClr,
  output logic              crcAccum,
  output logic              crcSend,
  output logic              writeGate,
  output logic              fmtDone,
  output logic [SEC_W-1:0]  secWritten,
  output logic              overrun
);

  fmtStrobe_t strobe;

  trkfmt_ctrl #(
    .GAP1_LEN(GAP1_LEN),
    .SYNC_LEN(SYNC_LEN),
    .GAP2_LEN(GAP2_LEN),
    .GAP3_LEN(GAP3_LEN),
    .DATA_LEN(DATA_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startFmt   (startFmt),
    .indexPulse (indexPulse),
    .sectorCount(sectorCount),
    .byteReady  (byteReady),
    .strobe     (strobe),
    .writeGate  (writeGate),
    .fmtDone    (fmtDone),
    .secWritten (secWritten),
    .overrun    (overrun)
  );

  trkfmt_dpath #(
    .FILL_BYTE(FILL_BYTE)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cylinder(cylinder),
    .head    (head),
    .wrByte  (wrByte),
    .markByte(markByte),
    .crcClr  (crcClr),
    .crcAccum(crcAccum),
    .crcSend (crcSend)
  );

endmodule

// File: tb/trkfmt_top_bench.sv
module trkfmt_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GAP1 = 16;
  localparam int SYNC = 12;
  localparam int GAP2 = 15;
  localparam int GAP3 = 20;
  localparam int DLEN = 256;
  localparam logic [7:0] FILL = 8'hE5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startFmt = 1'b0;
  logic        indexPulse = 1'b0;
  logic [15:0] cylinder = '0;
  logic [7:0]  head = '0;
  logic [7:0]  sectorCount = '0;
  logic        byteReady = 1'b0;
  logic [7:0]  wrByte;
  logic        markByte, crcClr, crcAccum, crcSend, writeGate, fmtDone, overrun;
  logic [7:0]  secWritten;

  int checks = 0;
  int fails = 0;
  int gapCycles = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trkfmt_top u_trkfmt_top (
    .clk(clk), .rstN(rstN), .startFmt(startFmt), .indexPulse(indexPulse),
    .cylinder(cylinder), .head(head), .sectorCount(sectorCount), .byteReady(byteReady),
    .wrByte(wrByte), .markByte(markByte), .crcClr(crcClr), .crcAccum(crcAccum),
    .crcSend(crcSend), .writeGate(writeGate), .fmtDone(fmtDone),
    .secWritten(secWritten), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one offered byte: compare {byte, mark, clr, accum, send, gate}, then consume it
  task automatic slot(input logic [7:0] eb, input bit em, input bit eclr,
                      input bit eacc, input bit esend, input string req);
    logic [12:0] exp;
    exp = {eb, em, eclr, eacc, esend, 1'b1};
    check({wrByte, markByte, crcClr, crcAccum, crcSend, writeGate} == exp, req, "slot",
          {wrByte, markByte, crcClr, crcAccum, crcSend, writeGate}, exp);
    for (int g = 0; g < gapCycles; g++) begin
      @(negedge clk);
      check({wrByte, markByte, crcClr, crcAccum, crcSend, writeGate} == exp, "R11", "hold",
            {wrByte, markByte, crcClr, crcAccum, crcSend, writeGate}, exp);
    end
    byteReady = 1'b1;
    @(negedge clk);
    byteReady = 1'b0;
  endtask

  task automatic startAndIndex(input logic [15:0] cyl, input logic [7:0] hd, input logic [7:0] n);
    cylinder = cyl; head = hd; sectorCount = n;
    startFmt = 1'b1;
    @(negedge clk);
    startFmt = 1'b0;
    cylinder = ~cyl; head = ~hd;  // later changes must not matter (R5 capture)
    for (int k = 0; k < 3; k++) begin
      byteReady = 1'b1;
      @(negedge clk);
      byteReady = 1'b0;
      check(writeGate == 1'b0, "R1", "gate while armed", writeGate, 0);
    end
    indexPulse = 1'b1;
    @(negedge clk);
    check(writeGate == 1'b1, "R1", "gate after index", writeGate, 1);
    repeat (2) @(negedge clk);
    indexPulse = 1'b0;
  endtask

  task automatic endIndex(input int expSecs, input bit expOver);
    indexPulse = 1'b1;
    @(negedge clk);
    check(writeGate == 1'b0, "R9", "gate at end", writeGate, 0);
    check(fmtDone == 1'b1, "R9", "done pulse", fmtDone, 1);
    check(secWritten == 8'(expSecs), "R9", "sectors written", secWritten, expSecs);
    check(overrun == expOver, "R10", "overrun", overrun, expOver);
    indexPulse = 1'b0;
    @(negedge clk);
    check(fmtDone == 1'b0, "R9", "done single cycle", fmtDone, 0);
    check(overrun == expOver, "R10", "overrun held", overrun, expOver);
  endtask

  // mode 0: full pass; mode 1: cut before data of sector cutSec; mode 2: end inside last gap 3
  task automatic runPass(input logic [15:0] cyl, input logic [7:0] hd, input int n,
                         input int mode, input int cutSec);
    startAndIndex(cyl, hd, 8'(n));
    for (int i = 0; i < GAP1; i++) slot(8'h4E, 0, 0, 0, 0, "R2");
    for (int s = 1; s <= n; s++) begin
      for (int i = 0; i < SYNC; i++) slot(8'h00, 0, 0, 0, 0, "R3");
      slot(8'hA1, 1, 1, 1, 0, "R4");
      slot(8'hFE, 0, 0, 1, 0, "R4");
      slot(cyl[15:8], 0, 0, 1, 0, "R5");
      slot(cyl[7:0], 0, 0, 1, 0, "R5");
      slot(hd, 0, 0, 1, 0, "R5");
      slot(8'(s), 0, 0, 1, 0, "R5");
      slot(8'h00, 0, 0, 0, 1, "R6");
      slot(8'h00, 0, 0, 0, 1, "R6");
      for (int i = 0; i < GAP2; i++) slot(8'h4E, 0, 0, 0, 0, "R8");
      if (mode == 1 && s == cutSec) begin
        endIndex(s - 1, 1'b1);
        return;
      end
      for (int i = 0; i < SYNC; i++) slot(8'h00, 0, 0, 0, 0, "R3");
      slot(8'hA1, 1, 1, 1, 0, "R4");
      slot(8'hF8, 0, 0, 1, 0, "R4");
      for (int i = 0; i < DLEN; i++) slot(FILL, 0, 0, 1, 0, "R7");
      slot(8'h00, 0, 0, 0, 1, "R6");
      slot(8'h00, 0, 0, 0, 1, "R6");
      if (mode == 2 && s == n) begin
        for (int i = 0; i < 5; i++) slot(8'h4E, 0, 0, 0, 0, "R8");
        endIndex(n, 1'b0);
        return;
      end
      for (int i = 0; i < GAP3; i++) slot(8'h4E, 0, 0, 0, 0, "R8");
    end
    for (int i = 0; i < 7; i++) slot(8'h4E, 0, 0, 0, 0, "R8");
    endIndex(n, 1'b0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(writeGate == 1'b0, "R1", "reset gate", writeGate, 0);
    check(fmtDone == 1'b0, "R9", "reset done", fmtDone, 0);
    check(overrun == 1'b0, "R10", "reset overrun", overrun, 0);
    check(markByte == 1'b0, "R4", "reset mark", markByte, 0);
    // index without start: nothing happens (R1)
    indexPulse = 1'b1;
    @(negedge clk);
    indexPulse = 1'b0;
    @(negedge clk);
    check(writeGate == 1'b0, "R1", "index while idle", writeGate, 0);

    for (int n = 1; n <= 3; n++) begin
      logic [15:0] c;
      c = (n == 1) ? 16'h0000 : (n == 2) ? 16'h1234 : 16'hFFFF;
      runPass(c, 8'(n * 5), n, 0, 0);
    end
    gapCycles = 2;
    runPass(16'h0A5C, 8'h03, 1, 0, 0);
    gapCycles = 0;
    runPass(16'h0101, 8'h07, 3, 1, 2);   // R10: cut in sector 2
    runPass(16'h0202, 8'h01, 2, 1, 1);   // R10: cut in sector 1
    runPass(16'h00C8, 8'h02, 2, 2, 0);   // ends inside last gap 3: no overrun
    runPass(16'h8001, 8'h0F, 1, 0, 0);   // overrun cleared by a new pass

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule